// File: doc/BRIEF.md
# TLB Array Debug Access Port

This block lets privileged software inspect and modify single entries of the level-one translation buffer storage through a small register-command interface. There are two independent sides, one for instruction fetch and one for data. Each side holds three storage arrays: a tag array with two words per entry, an attribute array and a physical-address array. Each side also has two staging words. The host never reaches an array directly. It loads the staging words, then issues an array command whose operand is an entry locator. To read an entry, it issues an array-read command that fills staging, then fetches the staging words.

A command has a four-bit selector, a three-bit operation code, a direction bit (host writes or host reads) and a 32-bit operand. Selectors 0 and 1 reach the data side and the instruction side for staging transfers and array writes. Selectors 2 and 3 issue array reads on the data side and the instruction side. Each command finishes in the cycle it is accepted. One cycle later a response returns the read word together with denied and undefined flags.

Top module: `tlb_dbg_port`

## Requirements
- R1: A command with `cmd_secure` low sets `rsp_denied`, returns zero data and leaves all staging words and array entries unchanged. Permission is checked before decoding, so `rsp_undef` stays low.
- R2: Selector 0 (data side) or 1 (instruction side) with op 0 moves the operand into staging word 0 when `cmd_write`=1, and returns staging word 0 on `rsp_rdata` when `cmd_write`=0. Op 1 does the same for staging word 1. Word 1 keeps only its low `TAG1_W` bits and reads back zero-extended.
- R3: Commands on one side never change the staging words or arrays of the other side.
- R4: With `cmd_write`=1, selector 0/1 with op 2, 3 or 4 writes the tag, attribute or physical-address array entry named by the operand. Selector 2/3 with the same op codes reads that entry into staging.
- R5: A tag-array write stores both staging words. A tag-array read loads both staging words.
- R6: Attribute and physical-address writes store only staging word 0, truncated to the array width. Reading either array reloads word 0, zero-extended, and leaves word 1 unchanged.
- R7: The entry index is taken from the locator: way = operand[31:30], set = operand[17:12]. All other operand bits are ignored.
- R8: Any other combination of selector, op and direction raises `rsp_undef`, returns zero data and changes no state. This covers selectors above 3, ops 5 to 7, ops 0/1 with selectors 2/3, and array commands with `cmd_write`=0.
- R9: `rsp_valid` goes high exactly in the cycle after each accepted command. A staging read issued in the cycle right after an array read returns the new contents.
- R10: After reset, all staging words are zero and `rsp_valid`, `rsp_undef`, `rsp_denied` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_secure | input | 1 | Requester is in a secure privileged mode |
| cmd_write | input | 1 | 1: host supplies operand; 0: host reads a staging word |
| cmd_sel | input | 4 | Secondary register selector |
| cmd_op | input | 3 | Operation code |
| cmd_wdata | input | 32 | Operand: staging data or entry locator |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_rdata | output | 32 | Staging word returned by a host read, otherwise zero |
| rsp_undef | output | 1 | Previous command was undefined |
| rsp_denied | output | 1 | Previous command lacked privilege |

## Verification
The hardest case to reach is a staging fetch that follows an array read in the very next cycle. This must be tested after the same entry was rewritten with other staging data, so that a stale or skipped load gives a wrong word. The bench first fills every entry on both sides with random contents. It then runs a long random mix in which reads and writes on each side follow each other with no idle cycles. Directed sequences add locators with junk bits outside the way and set fields, and undefined or unprivileged commands placed between a staging write and its readback.

// File: rtl/tlb_dbg_pkg.sv
// Package: shared array-select encoding and decoded command record
// for the TLB debug access port.
package tlb_dbg_pkg;
    typedef enum logic [1:0] {
        ARR_TAG  = 2'd0,
        ARR_ATTR = 2'd1,
        ARR_PA   = 2'd2,
        ARR_NONE = 2'd3
    } arr_e;

    typedef struct packed {
        logic stg_wr;   // host writes a staging word
        logic stg_rd;   // host reads a staging word
        logic arr_wr;   // staging -> array entry
        logic arr_rd;   // array entry -> staging
        logic side;     // 0 data, 1 instruction
        logic word;     // staging word select
        arr_e arr;      // array select
        logic undef;    // undefined combination
        logic denied;   // privilege failure
    } dec_t;
endpackage

// File: rtl/tlb_dbg_decode.sv
// Module: tlb_dbg_decode
// Purely combinational command decoder. It checks privilege first, then
// maps selector/op/direction to one action or to the undefined flag.
// Assumes: inputs are only meaningful while valid is high.
module tlb_dbg_decode
    import tlb_dbg_pkg::*;
(
    input  logic       valid,
    input  logic       secure,
    input  logic       wr,
    input  logic [3:0] sel,
    input  logic [2:0] op,
    output dec_t       dec
);
    // Decode one command into an action record.
    always_comb begin
        dec     = '0;
        dec.arr = ARR_NONE;
        if (valid) begin
            if (!secure) begin
                dec.denied = 1'b1;
            end else begin
                case (sel)
                    4'd0, 4'd1: begin
                        dec.side = sel[0];
                        if (op <= 3'd1) begin
                            dec.word   = op[0];
                            dec.stg_wr = wr;
                            dec.stg_rd = !wr;
                        end else if (op <= 3'd4 && wr) begin
                            dec.arr_wr = 1'b1;
                            dec.arr    = arr_e'(op[1:0] - 2'd2);
                        end else begin
                            dec.undef = 1'b1;
                        end
                    end
                    4'd2, 4'd3: begin
                        dec.side = sel[0];
                        if (op >= 3'd2 && op <= 3'd4 && wr) begin
                            dec.arr_rd = 1'b1;
                            dec.arr    = arr_e'(op[1:0] - 2'd2);
                        end else begin
                            dec.undef = 1'b1;
                        end
                    end
                    default: dec.undef = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/tlb_dbg_ram.sv
// Module: tlb_dbg_ram
// Behavioural single-port array with synchronous write and asynchronous
// read. It stands in for one TLB storage array.
// Assumes: contents are undefined until written.
module tlb_dbg_ram #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one entry on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/tlb_dbg_side.sv
// Module: tlb_dbg_side
// One side (instruction or data): two staging words plus tag, attribute
// and physical-address arrays. A staging write, an array write or an
// array read completes in a single cycle.
// Assumes: at most one of stg_wr/arr_wr/arr_rd is high per cycle;
// PA_W and ATTR_W do not exceed DW.
module tlb_dbg_side
    import tlb_dbg_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned ATTR_W = 16,
    parameter int unsigned PA_W   = 32,
    parameter int unsigned TAG1_W = 8,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_wr,
    input  logic              stg_word,
    input  logic [DW-1:0]     wdata,
    input  logic              arr_wr,
    input  logic              arr_rd,
    input  arr_e              arr_sel,
    input  logic [IDX_W-1:0]  idx,
    output logic [DW-1:0]     stage0,
    output logic [TAG1_W-1:0] stage1
);
    logic [DW-1:0]     tag0_q;
    logic [TAG1_W-1:0] tag1_q;
    logic [ATTR_W-1:0] attr_q;
    logic [PA_W-1:0]   pa_q;
    logic [DW-1:0]     attr_ext, pa_ext;
    logic              we_tag, we_attr, we_pa;

    assign we_tag  = arr_wr && (arr_sel == ARR_TAG);
    assign we_attr = arr_wr && (arr_sel == ARR_ATTR);
    assign we_pa   = arr_wr && (arr_sel == ARR_PA);

    tlb_dbg_ram #(.W(DW), .DEPTH(DEPTH)) u_tag0 (
        .clk(clk), .we(we_tag), .addr(idx), .wdata(stage0), .rdata(tag0_q));
    tlb_dbg_ram #(.W(TAG1_W), .DEPTH(DEPTH)) u_tag1 (
        .clk(clk), .we(we_tag), .addr(idx), .wdata(stage1), .rdata(tag1_q));
    tlb_dbg_ram #(.W(ATTR_W), .DEPTH(DEPTH)) u_attr (
        .clk(clk), .we(we_attr), .addr(idx), .wdata(stage0[ATTR_W-1:0]), .rdata(attr_q));
    tlb_dbg_ram #(.W(PA_W), .DEPTH(DEPTH)) u_pa (
        .clk(clk), .we(we_pa), .addr(idx), .wdata(stage0[PA_W-1:0]), .rdata(pa_q));

    // Zero-extend the narrow array outputs to a staging word.
    always_comb begin
        attr_ext = '0;
        attr_ext[ATTR_W-1:0] = attr_q;
        pa_ext = '0;
        pa_ext[PA_W-1:0] = pa_q;
    end

    // Staging word update from the host or from an array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage0 <= '0;
            stage1 <= '0;
        end else if (stg_wr) begin
            if (stg_word) stage1 <= wdata[TAG1_W-1:0];
            else          stage0 <= wdata;
        end else if (arr_rd) begin
            case (arr_sel)
                ARR_TAG: begin
                    stage0 <= tag0_q;
                    stage1 <= tag1_q;
                end
                ARR_ATTR: stage0 <= attr_ext;
                ARR_PA:   stage0 <= pa_ext;
                default:  stage0 <= stage0;
            endcase
        end
    end

    // R5: a tag read brings the stored second word into staging word 1.
    a_r5_tag_read_loads_w1: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && arr_sel == ARR_TAG) |=> (stage1 == $past(tag1_q)));

    // R6: attribute and address reads leave staging word 1 alone.
    a_r6_narrow_read_keeps_w1: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && (arr_sel == ARR_ATTR || arr_sel == ARR_PA)) |=> $stable(stage1));

    // R4: array writes never disturb staging.
    a_r4_arr_write_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && !stg_wr && !arr_rd) |=> ($stable(stage0) && $stable(stage1)));
endmodule

// File: rtl/tlb_dbg_port.sv
// Module: tlb_dbg_port
// Top of the TLB array debug access port. It decodes each command,
// steers it to the data side (index 0) or the instruction side (index 1),
// and registers a one-cycle-later response.
// Assumes: one command per cycle while cmd_valid is high; no back-pressure.
module tlb_dbg_port
    import tlb_dbg_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned WAY_W   = 2,
    parameter int unsigned SET_W   = 6,
    parameter int unsigned WAY_LSB = 30,
    parameter int unsigned SET_LSB = 12,
    parameter int unsigned ATTR_W  = 16,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned TAG1_W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_secure,
    input  logic          cmd_write,
    input  logic [3:0]    cmd_sel,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_undef,
    output logic          rsp_denied
);
    localparam int unsigned IDX_W   = WAY_W + SET_W;
    localparam int unsigned N_SIDES = 2;

    dec_t              dec;
    logic [IDX_W-1:0]  idx;
    logic [DW-1:0]     stg0 [N_SIDES];
    logic [TAG1_W-1:0] stg1 [N_SIDES];
    logic [DW-1:0]     rd_word;
    logic [2*DW+2*TAG1_W-1:0] stg_all;

    tlb_dbg_decode u_dec (
        .valid(cmd_valid), .secure(cmd_secure), .wr(cmd_write),
        .sel(cmd_sel), .op(cmd_op), .dec(dec));

    assign idx = {cmd_wdata[WAY_LSB +: WAY_W], cmd_wdata[SET_LSB +: SET_W]};

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        logic hit;
        assign hit = (dec.side == 1'(s));
        tlb_dbg_side #(
            .DW(DW), .IDX_W(IDX_W), .ATTR_W(ATTR_W),
            .PA_W(PA_W), .TAG1_W(TAG1_W)
        ) u_side (
            .clk(clk), .rst_n(rst_n),
            .stg_wr(dec.stg_wr && hit), .stg_word(dec.word),
            .wdata(cmd_wdata),
            .arr_wr(dec.arr_wr && hit), .arr_rd(dec.arr_rd && hit),
            .arr_sel(dec.arr), .idx(idx),
            .stage0(stg0[s]), .stage1(stg1[s]));
    end

    assign stg_all = {stg0[1], stg0[0], stg1[1], stg1[0]};

    // Pick the staging word a host read returns.
    always_comb begin
        rd_word = '0;
        if (dec.word) rd_word[TAG1_W-1:0] = stg1[dec.side];
        else          rd_word = stg0[dec.side];
    end

    // Register the response one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_undef  <= 1'b0;
            rsp_denied <= 1'b0;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_rdata  <= dec.stg_rd ? rd_word : '0;
            rsp_undef  <= dec.undef;
            rsp_denied <= dec.denied;
        end
    end

    // R9: every command gets a response in the next cycle, and only then.
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    a_r9_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R1: an unprivileged command leaves all staging state unchanged.
    a_r1_denied_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_secure) |=> $stable(stg_all));

    // R1: a denied response carries no data and no undefined flag.
    a_r1_denied_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_rdata == '0 && !rsp_undef));

    // R8: an undefined command leaves all staging state unchanged.
    a_r8_undef_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_secure && (cmd_sel > 4'd3 || cmd_op > 3'd4)) |=> $stable(stg_all));

    // R8: the decoder picks at most one action or flag.
    a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.stg_wr, dec.stg_rd, dec.arr_wr, dec.arr_rd, dec.undef, dec.denied}));

    // R3: an access to one side leaves the other side's staging stable.
    a_r3_side_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_secure && cmd_sel == 4'd0) |=> ($stable(stg0[1]) && $stable(stg1[1])));
endmodule

// File: tb/sim_tlb_dbg_port.sv
`timescale 1ns/1ps
module sim_tlb_dbg_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_secure, cmd_write;
    logic [3:0]  cmd_sel;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_wdata;
    logic        rsp_valid, rsp_undef, rsp_denied;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state of both sides.
    bit [31:0] m_tag0 [2][256];
    bit [7:0]  m_tag1 [2][256];
    bit [15:0] m_attr [2][256];
    bit [31:0] m_pa   [2][256];
    bit [31:0] m_s0   [2];
    bit [7:0]  m_s1   [2];

    always #10 clk = ~clk;

    tlb_dbg_port u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_secure(cmd_secure),
        .cmd_write(cmd_write), .cmd_sel(cmd_sel), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_undef(rsp_undef), .rsp_denied(rsp_denied));

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Kind: 0 denied, 1 undef, 2 staging write, 3 staging read, 4 array write, 5 array read
    function automatic int exp_kind(input bit [3:0] sel, input bit [2:0] op,
                                    input bit wr, input bit sec);
        if (!sec) return 0;
        if (sel <= 1) begin
            if (op <= 1) return wr ? 2 : 3;
            if (op <= 4 && wr) return 4;
            return 1;
        end
        if (sel <= 3) begin
            if (op >= 2 && op <= 4 && wr) return 5;
            return 1;
        end
        return 1;
    endfunction

    function automatic int idx_of(input bit [31:0] loc);
        return int'(loc[31:30]) * 64 + int'(loc[17:12]);
    endfunction

    // Issue one command at a falling edge, check its response at the next.
    task automatic cmd(input bit [3:0] sel, input bit [2:0] op, input bit wr,
                       input bit sec, input bit [31:0] d, input string tag);
        int k, s, ix;
        bit [31:0] e_rd;
        k  = exp_kind(sel, op, wr, sec);
        s  = int'(sel[0]);
        ix = idx_of(d);
        e_rd = '0;
        case (k)
            2: if (op[0]) m_s1[s] = d[7:0]; else m_s0[s] = d;
            3: e_rd = op[0] ? {24'd0, m_s1[s]} : m_s0[s];
            4: case (op)
                   3'd2: begin m_tag0[s][ix] = m_s0[s]; m_tag1[s][ix] = m_s1[s]; end
                   3'd3: m_attr[s][ix] = m_s0[s][15:0];
                   default: m_pa[s][ix] = m_s0[s];
               endcase
            5: case (op)
                   3'd2: begin m_s0[s] = m_tag0[s][ix]; m_s1[s] = m_tag1[s][ix]; end
                   3'd3: m_s0[s] = {16'd0, m_attr[s][ix]};
                   default: m_s0[s] = m_pa[s][ix];
               endcase
            default: ;
        endcase
        cmd_valid = 1'b1; cmd_sel = sel; cmd_op = op; cmd_write = wr;
        cmd_secure = sec; cmd_wdata = d;
        @(negedge clk);
        chk("R9", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R1", "rsp_denied", {31'd0, rsp_denied}, {31'd0, k == 0});
        chk("R8", "rsp_undef", {31'd0, rsp_undef}, {31'd0, k == 1});
        chk(tag, "rsp_rdata", rsp_rdata, e_rd);
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R9", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_secure = 1'b0; cmd_write = 1'b0;
        cmd_sel = '0; cmd_op = '0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R10", "rsp_undef after reset", {31'd0, rsp_undef}, 32'd0);
        chk("R10", "rsp_rdata after reset", rsp_rdata, 32'd0);
        cmd(4'd0, 3'd0, 1'b0, 1'b1, 32'd0, "R10");
        cmd(4'd1, 3'd1, 1'b0, 1'b1, 32'd0, "R10");

        // Fill every entry on both sides (R4, R5, R6).
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 256; i++) begin
                bit [31:0] loc;
                loc = {i[7:6], 12'd0, i[5:0], 12'd0};
                cmd(4'(s), 3'd0, 1'b1, 1'b1, $urandom, "R2");
                cmd(4'(s), 3'd1, 1'b1, 1'b1, $urandom, "R2");
                cmd(4'(s), 3'd2, 1'b1, 1'b1, loc, "R5");
                cmd(4'(s), 3'd0, 1'b1, 1'b1, $urandom, "R2");
                cmd(4'(s), 3'd3, 1'b1, 1'b1, loc, "R6");
                cmd(4'(s), 3'd0, 1'b1, 1'b1, $urandom, "R2");
                cmd(4'(s), 3'd4, 1'b1, 1'b1, loc, "R6");
            end
        end

        // R2: word 1 truncation and zero-extension.
        cmd(4'd0, 3'd1, 1'b1, 1'b1, 32'hDEAD_BEA5, "R2");
        cmd(4'd0, 3'd1, 1'b0, 1'b1, 32'd0, "R2");

        // R3: data-side writes leave the instruction side alone.
        cmd(4'd1, 3'd0, 1'b1, 1'b1, 32'h1111_2222, "R3");
        cmd(4'd0, 3'd0, 1'b1, 1'b1, 32'h3333_4444, "R3");
        cmd(4'd1, 3'd0, 1'b0, 1'b1, 32'd0, "R3");

        // R7: junk outside way/set fields; read back with a clean locator.
        cmd(4'd0, 3'd0, 1'b1, 1'b1, 32'hCAFE_0001, "R7");
        cmd(4'd0, 3'd4, 1'b1, 1'b1, 32'h8003_5FFF | 32'h3FFC_0000 & 32'h0, "R7");
        cmd(4'd0, 3'd4, 1'b1, 1'b1, {2'b10, 12'hABC, 6'd53, 12'h5A5}, "R7");
        cmd(4'd0, 3'd0, 1'b1, 1'b1, 32'd0, "R7");
        cmd(4'd2, 3'd4, 1'b1, 1'b1, {2'b10, 12'd0, 6'd53, 12'd0}, "R7");
        cmd(4'd0, 3'd0, 1'b0, 1'b1, 32'd0, "R7");

        // R5/R9: tag read, then both staging words fetched back to back.
        cmd(4'd3, 3'd2, 1'b1, 1'b1, {2'b01, 12'd0, 6'd7, 12'd0}, "R5");
        cmd(4'd1, 3'd0, 1'b0, 1'b1, 32'd0, "R9");
        cmd(4'd1, 3'd1, 1'b0, 1'b1, 32'd0, "R5");

        // R6: attribute read keeps word 1 and zero-extends word 0.
        cmd(4'd1, 3'd1, 1'b1, 1'b1, 32'h0000_005C, "R6");
        cmd(4'd3, 3'd3, 1'b1, 1'b1, {2'b11, 12'd0, 6'd63, 12'd0}, "R6");
        cmd(4'd1, 3'd0, 1'b0, 1'b1, 32'd0, "R6");
        cmd(4'd1, 3'd1, 1'b0, 1'b1, 32'd0, "R6");

        // R8: undefined commands, then staging readback.
        cmd(4'd0, 3'd0, 1'b1, 1'b1, 32'h5555_AAAA, "R8");
        cmd(4'd5, 3'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        cmd(4'd0, 3'd6, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        cmd(4'd2, 3'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        cmd(4'd2, 3'd2, 1'b0, 1'b1, 32'd0, "R8");
        cmd(4'd0, 3'd2, 1'b0, 1'b1, 32'd0, "R8");
        cmd(4'd0, 3'd0, 1'b0, 1'b1, 32'd0, "R8");

        // R1: unprivileged write and array read are dropped.
        cmd(4'd0, 3'd0, 1'b1, 1'b0, 32'h0BAD_0BAD, "R1");
        cmd(4'd2, 3'd2, 1'b1, 1'b0, 32'd0, "R1");
        cmd(4'd0, 3'd0, 1'b0, 1'b0, 32'd0, "R1");
        cmd(4'd0, 3'd0, 1'b0, 1'b1, 32'd0, "R1");
        idle();

        // Random mix across both sides.
        for (int n = 0; n < 4000; n++) begin
            bit [3:0] sel;
            bit [2:0] op;
            sel = 4'($urandom_range(0, 4));
            op  = 3'($urandom_range(0, 5));
            cmd(sel, op, ($urandom % 8) != 0, ($urandom % 16) != 0, $urandom, "R4");
            if ((n % 500) == 0) idle();
        end
        idle();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule